// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Handler

This block takes writes aimed at the write-only end-of-interrupt register of a virtual CPU interface. Each accepted write names a virtual interrupt. It always lowers the running priority by clearing one bit of the active-priority bitmap. It can also retire the interrupt in a small bank of list-register entries. The two effects are controlled separately: a mode input picks whether deactivation happens or whether only the priority drop is performed.

When the retired entry is backed by a physical interrupt, the block passes the deactivation on to the physical distributor. It sends the physical ID held in the entry over a valid/ready channel. While that request waits to be accepted, the block refuses further register writes. A request for a Group 0 physical interrupt is suppressed unless the distributor's security-disable control is set.

The surrounding logic loads the bitmap and the list entries through plain load ports. It observes their contents on flat output vectors.

Top module: `veoi_handler`

## Requirements
- R1: After reset the bitmap, every list entry and the miss counter read zero, `pd_valid` is 0 and `wr_ready` is 1.
- R2: A write is taken on a clock edge where `wr_valid` and `wr_ready` are both 1. Only a taken write at offset 0x010 has any effect. Data bits [31:25] never influence the result.
- R3: With `affinity_en` low, the interrupt ID is data bits [9:0], and bits [24:10] are ignored (including the source-CPU field in [12:10]). With `affinity_en` high, the ID is bits [24:0], and an ID of 1024 or more matches no entry.
- R4: An ID from 1020 to 1023 changes neither the bitmap, nor any list entry, nor the miss counter, and raises no forward request.
- R5: An effective write clears the lowest-index set bit of `apr_q` on the edge that takes the write. An all-zero bitmap stays zero.
- R6: With `eoi_mode`=0, the lowest-index entry that is valid and whose virtual ID equals the write ID has state bit 1 (active) cleared, and its pending bit is kept. State coding: 0 inactive, 1 pending, 2 active, 3 pending and active. With `eoi_mode`=1 no entry changes.
- R7: With `eoi_mode`=0 and no matching entry, `err_count` rises by one, saturating at its maximum, and no entry changes.
- R8: If the matched entry has hw=1, `pd_valid` rises on the same edge with `pd_id` equal to the entry's physical ID. The request is suppressed when the entry's group bit is 0 (Group 0) and `sec_disable` is 0.
- R9: While `pd_valid` is 1 and `pd_ready` is 0, `pd_valid` and `pd_id` hold, and `wr_ready` is 0. The request retires on the edge where `pd_ready` is 1.
- R10: `apr_wr_en` loads `apr_q` and overrides a drop in the same cycle. `lr_wr_en` writes entry `lr_wr_idx` and overrides a deactivation of that entry in the same cycle. Entry i occupies `lr_flat[25*i +: 25]` with fields valid[24], hw[23], group[22], state[21:20], physical ID[19:10], virtual ID[9:0]; `lr_wr_data` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write can be taken (low while a forward is outstanding) |
| wr_addr | input | ADDR_W | Byte offset within the interface window |
| wr_data | input | 32 | Write data carrying the interrupt ID |
| eoi_mode | input | 1 | 0: drop and deactivate, 1: drop only |
| affinity_en | input | 1 | Affinity routing enabled (selects ID decode) |
| sec_disable | input | 1 | Distributor security-disable control |
| apr_wr_en | input | 1 | Load the active-priority bitmap |
| apr_wr_data | input | APR_W | Bitmap load value |
| lr_wr_en | input | 1 | Load one list entry |
| lr_wr_idx | input | IDX_W | Entry index to load |
| lr_wr_data | input | 25 | Entry load value |
| apr_q | output | APR_W | Active-priority bitmap |
| lr_flat | output | 25*NUM_LR | All list entries |
| err_count | output | ERR_W | Count of deactivations that found no entry |
| pd_valid | output | 1 | Physical deactivate request valid |
| pd_ready | input | 1 | Distributor accepts the request |
| pd_id | output | 10 | Physical interrupt ID of the request |

## Verification
Two entries carry the same virtual ID, so a design that searched from the top would retire the wrong one. A pending-and-active entry is retired, so a design that zeroed the whole state would also lose the pending bit. Writes carry set reserved bits, a source-CPU field, an ID above the entry width with affinity on, an off-offset address and the four special IDs. A design that decoded any of these wrongly would retire, miss or drop where it should not. The distributor is held off while a second write waits, and a load is made in the same cycle as a drop. A design that let the write through, changed the outgoing ID or let the drop override the load would depart from the cycle model.

// File: rtl/veoi_pkg.sv
package veoi_pkg;
  localparam int LR_ID_W = 10;
  localparam int RAW_ID_W = 25;

  typedef struct packed {
    logic               valid;
    logic               hw;
    logic               grp;
    logic [1:0]         state;
    logic [LR_ID_W-1:0] pid;
    logic [LR_ID_W-1:0] vid;
  } lr_t;

  localparam int LR_W = $bits(lr_t);

  // Effective interrupt ID from the written word
  function automatic logic [RAW_ID_W-1:0] eff_id(input logic [31:0] d, input logic aff);
    if (aff) return d[RAW_ID_W-1:0];
    return {{(RAW_ID_W-LR_ID_W){1'b0}}, d[LR_ID_W-1:0]};
  endfunction

  function automatic logic is_special(input logic [RAW_ID_W-1:0] id);
    return (id >= RAW_ID_W'(1020)) && (id <= RAW_ID_W'(1023));
  endfunction

  // Bitmap with its lowest set bit removed
  function automatic logic [63:0] drop_lowest(input logic [63:0] x);
    return x & (x - 64'd1);
  endfunction
endpackage

// File: rtl/veoi_wr_decode.sv
module veoi_wr_decode
  import veoi_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int EOI_OFS = 16
) (
  input  logic                wr_fire,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                affinity_en,
  input  logic                eoi_mode,
  output logic                eoi_hit,
  output logic                special,
  output logic                drop_req,
  output logic                deact_req,
  output logic [LR_ID_W-1:0]  lookup_id,
  output logic                id_fits
);
  logic [RAW_ID_W-1:0] id;

  always_comb begin
    id        = eff_id(wr_data, affinity_en);
    eoi_hit   = wr_fire && (wr_addr == ADDR_W'(EOI_OFS));
    special   = is_special(id);
    drop_req  = eoi_hit && !special;
    deact_req = drop_req && !eoi_mode;
    lookup_id = id[LR_ID_W-1:0];
    id_fits   = (id[RAW_ID_W-1:LR_ID_W] == '0);
  end
endmodule

// File: rtl/veoi_apr.sv
module veoi_apr
  import veoi_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         drop,
  output logic [W-1:0] apr_q
);
  logic [63:0] wide;
  logic [W-1:0] dropped;

  always_comb begin
    wide    = 64'(apr_q);
    dropped = W'(drop_lowest(wide));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       apr_q <= '0;
    else if (load_en) apr_q <= load_val;
    else if (drop)    apr_q <= dropped;
  end
endmodule

// File: rtl/veoi_lr_bank.sv
module veoi_lr_bank
  import veoi_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_idx,
  input  lr_t                ld_data,
  input  logic               deact,
  input  logic [LR_ID_W-1:0] lookup_id,
  input  logic               id_fits,
  output logic               match,
  output logic               sel_hw,
  output logic               sel_grp,
  output logic [LR_ID_W-1:0] sel_pid,
  output logic [N*LR_W-1:0]  lr_flat
);
  lr_t              ent [N];
  logic [N-1:0]     hit;
  logic [IDX_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = N - 1; k >= 0; k--)
      if (hit[k]) sel = IDX_W'(k);
    match   = |hit;
    sel_hw  = ent[sel].hw;
    sel_grp = ent[sel].grp;
    sel_pid = ent[sel].pid;
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit[i] = ent[i].valid && id_fits && (ent[i].vid == lookup_id);
    assign lr_flat[i*LR_W +: LR_W] = ent[i];

    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (ld_en && ld_idx == IDX_W'(i))
        ent[i] <= ld_data;
      else if (deact && match && sel == IDX_W'(i))
        ent[i].state[1] <= 1'b0;
    end
  end
endmodule

// File: rtl/veoi_fwd.sv
module veoi_fwd
  import veoi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [LR_ID_W-1:0] req_pid,
  input  logic               pd_ready,
  output logic               pd_valid,
  output logic [LR_ID_W-1:0] pd_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_valid <= 1'b0;
      pd_id    <= '0;
    end else if (req) begin
      pd_valid <= 1'b1;
      pd_id    <= req_pid;
    end else if (pd_ready) begin
      pd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/veoi_handler.sv
module veoi_handler
  import veoi_pkg::*;
#(
  parameter int NUM_LR  = 4,
  parameter int APR_W   = 32,
  parameter int ADDR_W  = 12,
  parameter int ERR_W   = 8,
  parameter int EOI_OFS = 16,
  localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic                   eoi_mode,
  input  logic                   affinity_en,
  input  logic                   sec_disable,
  input  logic                   apr_wr_en,
  input  logic [APR_W-1:0]       apr_wr_data,
  input  logic                   lr_wr_en,
  input  logic [IDX_W-1:0]       lr_wr_idx,
  input  logic [LR_W-1:0]        lr_wr_data,
  output logic [APR_W-1:0]       apr_q,
  output logic [NUM_LR*LR_W-1:0] lr_flat,
  output logic [ERR_W-1:0]       err_count,
  output logic                   pd_valid,
  input  logic                   pd_ready,
  output logic [LR_ID_W-1:0]     pd_id
);
  // Named events, visible to the checker
  logic               wr_fire, eoi_hit, special_evt, drop_evt, deact_evt;
  logic               miss_evt, fwd_evt, match;
  logic               sel_hw, sel_grp, id_fits;
  logic [LR_ID_W-1:0] lookup_id, sel_pid;

  assign wr_ready = !pd_valid;
  assign wr_fire  = wr_valid && wr_ready;

  veoi_wr_decode #(.ADDR_W(ADDR_W), .EOI_OFS(EOI_OFS)) u_dec (
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .affinity_en(affinity_en), .eoi_mode(eoi_mode),
    .eoi_hit(eoi_hit), .special(special_evt), .drop_req(drop_evt),
    .deact_req(deact_evt), .lookup_id(lookup_id), .id_fits(id_fits)
  );

  veoi_apr #(.W(APR_W)) u_apr (
    .clk(clk), .rst_n(rst_n), .load_en(apr_wr_en), .load_val(apr_wr_data),
    .drop(drop_evt), .apr_q(apr_q)
  );

  veoi_lr_bank #(.N(NUM_LR)) u_lr (
    .clk(clk), .rst_n(rst_n), .ld_en(lr_wr_en), .ld_idx(lr_wr_idx),
    .ld_data(lr_t'(lr_wr_data)), .deact(deact_evt), .lookup_id(lookup_id),
    .id_fits(id_fits), .match(match), .sel_hw(sel_hw), .sel_grp(sel_grp),
    .sel_pid(sel_pid), .lr_flat(lr_flat)
  );

  assign miss_evt = deact_evt && !match;
  assign fwd_evt  = deact_evt && match && sel_hw && (sel_grp || sec_disable);

  veoi_fwd u_fwd (
    .clk(clk), .rst_n(rst_n), .req(fwd_evt), .req_pid(sel_pid),
    .pd_ready(pd_ready), .pd_valid(pd_valid), .pd_id(pd_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      err_count <= '0;
    else if (miss_evt && err_count != '1)
      err_count <= err_count + 1'b1;
  end
endmodule

// File: rtl/veoi_handler_chk.sv
module veoi_handler_chk
  import veoi_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int APR_W  = 32,
  parameter int ERR_W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_ready,
  input logic                   eoi_mode,
  input logic                   eoi_hit,
  input logic                   special_evt,
  input logic                   drop_evt,
  input logic                   miss_evt,
  input logic                   fwd_evt,
  input logic                   apr_wr_en,
  input logic                   lr_wr_en,
  input logic [APR_W-1:0]       apr_q,
  input logic [NUM_LR*LR_W-1:0] lr_flat,
  input logic [ERR_W-1:0]       err_count,
  input logic                   pd_valid,
  input logic                   pd_ready,
  input logic [LR_ID_W-1:0]     pd_id
);
  // R4
  special_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && special_evt && !apr_wr_en && !lr_wr_en)
      |=> ($stable(apr_q) && $stable(lr_flat) && $stable(err_count)));

  // R5
  one_bit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !apr_wr_en && apr_q != '0)
      |=> ($countones(apr_q) + 1 == $countones($past(apr_q))));

  // R6
  mode_one_keeps_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && eoi_mode && !lr_wr_en) |=> $stable(lr_flat));

  // R7
  miss_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && err_count != '1) |=> (err_count == $past(err_count) + 1'b1));

  // R8
  fwd_raises_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_evt |=> pd_valid);

  // R9
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && !pd_ready) |=> (pd_valid && $stable(pd_id)));

  // R9
  stall_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |-> !wr_ready);
endmodule

bind veoi_handler veoi_handler_chk #(.NUM_LR(NUM_LR), .APR_W(APR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .eoi_mode(eoi_mode),
  .eoi_hit(eoi_hit), .special_evt(special_evt), .drop_evt(drop_evt),
  .miss_evt(miss_evt), .fwd_evt(fwd_evt), .apr_wr_en(apr_wr_en),
  .lr_wr_en(lr_wr_en), .apr_q(apr_q), .lr_flat(lr_flat),
  .err_count(err_count), .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_id(pd_id)
);

// File: tb/veoi_handler_test.sv
module veoi_handler_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic eoi_mode = 1'b0, affinity_en = 1'b0, sec_disable = 1'b0;
  logic apr_wr_en = 1'b0;
  logic [31:0] apr_wr_data = '0;
  logic lr_wr_en = 1'b0;
  logic [1:0] lr_wr_idx = '0;
  logic [24:0] lr_wr_data = '0;
  logic pd_ready = 1'b1;
  logic wr_ready, pd_valid;
  logic [31:0] apr_q;
  logic [N*25-1:0] lr_flat;
  logic [7:0] err_count;
  logic [9:0] pd_id;

  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  veoi_handler uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .eoi_mode(eoi_mode),
    .affinity_en(affinity_en), .sec_disable(sec_disable),
    .apr_wr_en(apr_wr_en), .apr_wr_data(apr_wr_data), .lr_wr_en(lr_wr_en),
    .lr_wr_idx(lr_wr_idx), .lr_wr_data(lr_wr_data), .apr_q(apr_q),
    .lr_flat(lr_flat), .err_count(err_count), .pd_valid(pd_valid),
    .pd_ready(pd_ready), .pd_id(pd_id)
  );

  // ---------------- behavioural reference ----------------
  int m_apr[32];
  int m_val[N], m_hw[N], m_grp[N], m_st[N], m_pid[N], m_vid[N];
  int m_err, m_pdv, m_pdid;

  function automatic logic [N*25-1:0] m_flat();
    logic [N*25-1:0] f = '0;
    for (int k = 0; k < N; k++) begin
      logic [24:0] e;
      e = {m_val[k][0], m_hw[k][0], m_grp[k][0], m_st[k][1:0], m_pid[k][9:0], m_vid[k][9:0]};
      f[k*25 +: 25] = e;
    end
    return f;
  endfunction

  function automatic logic [31:0] m_aprv();
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) v[k] = (m_apr[k] != 0);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) m_apr[k] = 0;
      for (int k = 0; k < N; k++) begin
        m_val[k] = 0; m_hw[k] = 0; m_grp[k] = 0; m_st[k] = 0; m_pid[k] = 0; m_vid[k] = 0;
      end
      m_err = 0; m_pdv = 0; m_pdid = 0;
    end else begin
      int id, found;
      bit taken, sp;
      taken = wr_valid && (m_pdv == 0);
      if (m_pdv != 0 && pd_ready) m_pdv = 0;
      id = affinity_en ? int'(wr_data[24:0]) : int'(wr_data[9:0]);
      sp = (id >= 1020 && id <= 1023);
      if (taken && wr_addr == 12'h010 && !sp) begin
        for (int k = 0; k < 32; k++)
          if (m_apr[k] != 0) begin m_apr[k] = 0; break; end
        if (!eoi_mode) begin
          found = -1;
          for (int k = 0; k < N; k++)
            if (m_val[k] != 0 && m_vid[k] == id) begin found = k; break; end
          if (found < 0) begin
            if (m_err < 255) m_err++;
          end else begin
            if (m_st[found] >= 2) m_st[found] -= 2;
            if (m_hw[found] != 0 && (m_grp[found] != 0 || sec_disable)) begin
              m_pdv = 1; m_pdid = m_pid[found];
            end
          end
        end
      end
      if (apr_wr_en) for (int k = 0; k < 32; k++) m_apr[k] = apr_wr_data[k];
      if (lr_wr_en) begin
        m_val[lr_wr_idx] = lr_wr_data[24]; m_hw[lr_wr_idx] = lr_wr_data[23];
        m_grp[lr_wr_idx] = lr_wr_data[22]; m_st[lr_wr_idx] = lr_wr_data[21:20];
        m_pid[lr_wr_idx] = lr_wr_data[19:10]; m_vid[lr_wr_idx] = lr_wr_data[9:0];
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R5 bitmap", apr_q, m_aprv());
      vectors++;
      if (lr_flat !== m_flat()) begin
        fails++;
        $display("FAIL R6 entries: actual %0h expected %0h at %0t", lr_flat, m_flat(), $time);
      end
      check("R7 miss count", err_count, m_err);
      check("R8 request valid", pd_valid, m_pdv);
      if (m_pdv != 0) check("R8 request id", pd_id, m_pdid);
      check("R9 write ready", wr_ready, (m_pdv == 0));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [24:0] ent(bit v, bit hw, bit g, int st, int pid, int vid);
    return {v, hw, g, st[1:0], pid[9:0], vid[9:0]};
  endfunction

  task automatic load_lr(input int idx, input logic [24:0] e);
    @(negedge clk);
    lr_wr_en = 1'b1; lr_wr_idx = idx[1:0]; lr_wr_data = e;
    @(negedge clk);
    lr_wr_en = 1'b0;
  endtask

  task automatic load_apr(input logic [31:0] v);
    @(negedge clk);
    apr_wr_en = 1'b1; apr_wr_data = v;
    @(negedge clk);
    apr_wr_en = 1'b0;
  endtask

  task automatic eoi(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic int st_of(int k);
    return int'(lr_flat[k*25+20 +: 2]);
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bitmap", apr_q, 0);
    check("R1 entries", (lr_flat == '0), 1);
    check("R1 miss count", err_count, 0);
    check("R1 request", pd_valid, 0);
    check("R1 ready", wr_ready, 1);
    rst_n = 1'b1;

    load_lr(0, ent(1, 1, 1, 2, 100, 40));
    load_lr(1, ent(1, 0, 0, 3, 0, 41));
    load_lr(2, ent(1, 1, 0, 2, 200, 42));
    load_lr(3, ent(1, 0, 0, 2, 0, 40));
    load_apr(32'h0000_00F4);

    // R2 off-offset write does nothing
    eoi(12'h014, 32'd40);
    check("R2 off offset bitmap", apr_q, 32'hF4);
    check("R2 off offset entry", st_of(0), 2);

    // R2/R6/R8 reserved bits set, lowest duplicate retired and forwarded
    eoi(12'h010, 32'hFE00_0000 | 32'd40);
    check("R5 drop lowest", apr_q, 32'hF0);
    check("R6 lowest entry", st_of(0), 0);
    check("R6 duplicate kept", st_of(3), 2);
    check("R8 forward valid", pd_valid, 1);
    check("R8 forward id", pd_id, 100);

    // R3 source-CPU field ignored, R6 pending kept
    eoi(12'h010, (32'd5 << 10) | 32'd41);
    check("R3 src field ignored", st_of(1), 1);
    check("R6 no forward for sw", pd_valid, 0);

    // R3 affinity on: wide ID misses, R7
    affinity_en = 1'b1;
    eoi(12'h010, (32'd1 << 10) | 32'd42);
    check("R7 miss count", err_count, 1);
    check("R3 wide id no match", st_of(2), 2);
    affinity_en = 1'b0;

    // R4 special ID
    eoi(12'h010, 32'd1021);
    check("R4 special bitmap", apr_q, 32'hC0);
    check("R4 special count", err_count, 1);

    // R8 Group 0 forward suppressed
    eoi(12'h010, 32'd42);
    check("R8 group0 retired", st_of(2), 0);
    check("R8 group0 no request", pd_valid, 0);

    // R6 mode 1: drop only
    eoi_mode = 1'b1;
    eoi(12'h010, 32'd40);
    check("R6 mode1 entry", st_of(3), 2);
    check("R5 mode1 drop", apr_q, 32'h00);
    eoi(12'h010, 32'd40);
    check("R5 empty bitmap", apr_q, 32'h00);
    check("R7 mode1 no count", err_count, 1);
    eoi_mode = 1'b0;

    // R8 Group 0 forwarded when security disabled
    load_lr(2, ent(1, 1, 0, 2, 201, 42));
    sec_disable = 1'b1;
    eoi(12'h010, 32'd42);
    check("R8 secdis forward", pd_id, 201);
    sec_disable = 1'b0;

    // R9 stall behind an outstanding request
    load_lr(0, ent(1, 1, 1, 3, 300, 50));
    load_apr(32'h0000_000F);
    pd_ready = 1'b0;
    eoi(12'h010, 32'd50);
    fork
      eoi(12'h010, 32'd99);
      begin
        repeat (3) @(negedge clk);
        check("R9 held id", pd_id, 300);
        check("R9 write stalled", wr_ready, 0);
        check("R9 bitmap untouched", apr_q, 32'hE);
        pd_ready = 1'b1;
      end
    join
    check("R7 second miss", err_count, 2);

    // R10 load wins over drop in the same cycle
    @(negedge clk);
    apr_wr_en = 1'b1; apr_wr_data = 32'h30;
    wr_valid = 1'b1; wr_addr = 12'h010; wr_data = 32'd41;
    @(negedge clk);
    apr_wr_en = 1'b0; wr_valid = 1'b0;
    check("R10 load beats drop", apr_q, 32'h30);

    // Random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wr_valid = ($urandom_range(0, 2) != 0);
      wr_addr = ($urandom_range(0, 7) == 0) ? 12'h00C : 12'h010;
      wr_data = {$urandom_range(0, 127), 25'd0};
      if ($urandom_range(0, 9) == 0) wr_data[9:0] = 10'(1020 + $urandom_range(0, 3));
      else wr_data[9:0] = 10'($urandom_range(38, 45));
      if ($urandom_range(0, 5) == 0) wr_data[24:10] = 15'($urandom_range(0, 3));
      eoi_mode = ($urandom_range(0, 3) == 0);
      affinity_en = ($urandom_range(0, 3) == 0);
      sec_disable = ($urandom_range(0, 1) == 1);
      pd_ready = ($urandom_range(0, 2) != 0);
      apr_wr_en = ($urandom_range(0, 15) == 0);
      apr_wr_data = $urandom;
      lr_wr_en = ($urandom_range(0, 3) == 0);
      lr_wr_idx = 2'($urandom_range(0, 3));
      lr_wr_data = ent($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                       $urandom_range(0, 3), $urandom_range(0, 1023), $urandom_range(38, 45));
    end
    @(negedge clk);
    wr_valid = 1'b0; apr_wr_en = 1'b0; lr_wr_en = 1'b0; pd_ready = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule